// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output compare channel built around its own 16-bit up-counter and driven from an 8-bit register bus. Software loads a 16-bit compare value one byte at a time. The high byte waits in a temporary latch that the counter and the compare value share. The low-byte write then commits both bytes together. On each qualified timer tick the channel compares the counter with the active compare value. When they match, it raises a sticky flag and acts on a waveform pin as a 2-bit action field directs: toggle, clear, set or nothing.

Two counting schemes are available. In free-running mode the counter wraps at the top of its range, and compare writes take effect at once. In variable-period mode the active compare value is the period end. Compare writes land in a shadow copy, which moves into the active register at that period end, and the counter then restarts from zero. Software can strobe a forced compare, which moves the pin without touching the flag or the counter. Any write to the counter suppresses matching on the next timer tick, however late that tick comes.

Top module: `tcmp_channel`

## Requirements
- R1: After reset the counter, the compare value, the control field, the flag and the pin are all zero.
- R2: A write to the compare high byte (address 3) only loads the shared temporary latch and leaves the compare value unchanged. A write to the counter high byte (address 1) does the same for the counter.
- R3: A write to the compare low byte (address 2) loads {latch, data} in that cycle. In free-running mode (control bit 2 clear) the new value is visible on readback (addresses 2/3) on the next cycle.
- R4: In free-running mode the counter advances by one on each cycle with `tmr_tick` high, wraps from 0xFFFF to 0x0000, and holds while `tmr_tick` is low. A counter low-byte write (address 0) loads {latch, data}.
- R5: A match (tick with counter equal to compare, not suppressed) sets the flag (address 5, bit 0). Writing 1 to that bit clears it, and writing 0 has no effect.
- R6: On a match the pin follows control bits [1:0]: 00 unchanged, 01 toggle, 10 clear, 11 set.
- R7: In free-running mode, a control write with bit 3 set applies the written action field to the pin at once. It leaves the flag and the counter untouched. Bit 3 always reads back 0.
- R8: A control write with bit 3 set is ignored when the written mode bit 2 is 1 (variable-period mode).
- R9: After any counter write, the next timer tick produces no match, even if it comes many cycles later. The counter still advances on that tick.
- R10: A change of the action field takes effect for the very next match and is not held back with the shadowed compare value.
- R11: In variable-period mode, compare writes go to the shadow copy. On a match the counter returns to 0 and the shadow becomes the active compare value.
- R12: In variable-period mode, if the counter is written equal to the period end, that match is lost and the counter runs on through 0xFFFF to 0x0000.
- R13: The pin keeps its level when the mode bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_tick | input | 1 | Timer clock enable; qualifies counting and matching |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 cnt lo, 1 cnt hi, 2 cmp lo, 3 cmp hi, 4 control, 5 flag) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 8 | Combinational read data |
| wave_out | output | 1 | Waveform pin |

## Verification
A wrong suppression state shows up as a flag and pin change on the tick after a counter write, or as a missing one on a later tick. Either is visible one cycle after that tick. A corrupted temporary latch or shadow register shows up on the compare readback at the next cycle, or only at the next period end in variable-period mode. That is why every shadowed case is followed through a full period. A pin register that loses its level on a mode switch shows on `wave_out` in the cycle after the control write.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

   typedef enum logic [2:0] {
      A_CNT_LO = 3'd0,
      A_CNT_HI = 3'd1,
      A_CMP_LO = 3'd2,
      A_CMP_HI = 3'd3,
      A_CTRL   = 3'd4,
      A_STAT   = 3'd5
   } reg_addr_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_SET    = 2'd3
   } pin_act_e;

   localparam int CTRL_ACT_LSB = 0;
   localparam int CTRL_MODE_BIT = 2;
   localparam int CTRL_FORCE_BIT = 3;

   function automatic logic pin_next(input pin_act_e act, input logic cur);
      case (act)
         ACT_TOGGLE: pin_next = ~cur;
         ACT_CLEAR:  pin_next = 1'b0;
         ACT_SET:    pin_next = 1'b1;
         default:    pin_next = cur;
      endcase
   endfunction

endpackage

// File: rtl/tcmp_regif.sv
module tcmp_regif
   import tcmp_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int CNT_W   = 16,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [BUS_W-1:0] wr_data,
   output logic             cnt_ld,
   output logic             cmp_ld,
   output logic [CNT_W-1:0] ld_val,
   output pin_act_e         act_q,
   output logic             pwm_q,
   output logic             force_req,
   output pin_act_e         force_act,
   output logic             flag_clr
);

   logic [BUS_W-1:0] temp_q;
   logic             ctrl_wr;
   logic             mode_new;

   assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
   assign cnt_ld   = wr_en && (wr_addr == A_CNT_LO);
   assign cmp_ld   = wr_en && (wr_addr == A_CMP_LO);
   assign flag_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];
   assign ld_val   = {temp_q, wr_data};

   generate
      if (HAS_PWM) begin : g_mode
         assign mode_new = wr_data[CTRL_MODE_BIT];
      end else begin : g_nomode
         assign mode_new = 1'b0;
      end
   endgenerate

   assign force_req = ctrl_wr && wr_data[CTRL_FORCE_BIT] && !mode_new;
   assign force_act = pin_act_e'(wr_data[CTRL_ACT_LSB +: 2]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         temp_q <= '0;
      end else if (wr_en && ((wr_addr == A_CNT_HI) || (wr_addr == A_CMP_HI))) begin
         temp_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= ACT_NONE;
         pwm_q <= 1'b0;
      end else if (ctrl_wr) begin
         act_q <= force_act;
         pwm_q <= mode_new;
      end
   end

endmodule

// File: rtl/tcmp_counter.sv
module tcmp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_ld) begin
         cnt_q <= ld_val;
      end else if (tick) begin
         cnt_q <= restart ? '0 : cnt_q + ONE;
      end
   end

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
   parameter int CNT_W   = 16,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic             cnt_ld,
   input  logic             cmp_ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             pwm_q,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cmp_act_q,
   output logic             match_evt,
   output logic             flag_q,
   output logic             blk_q
);

   logic top_evt;

   assign match_evt = tick && (cnt_q == cmp_act_q) && !blk_q && !cnt_ld;
   assign top_evt   = match_evt && pwm_q;

   generate
      if (HAS_PWM) begin : g_shadow
         logic [CNT_W-1:0] shadow_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shadow_q <= '0;
            end else if (cmp_ld) begin
               shadow_q <= ld_val;
            end
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cmp_act_q <= '0;
            end else if (cmp_ld && !pwm_q) begin
               cmp_act_q <= ld_val;
            end else if (top_evt) begin
               cmp_act_q <= shadow_q;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cmp_act_q <= '0;
            end else if (cmp_ld) begin
               cmp_act_q <= ld_val;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_q <= 1'b0;
      end else if (cnt_ld) begin
         blk_q <= 1'b1;
      end else if (tick) begin
         blk_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (match_evt) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/tcmp_wave.sv
module tcmp_wave
   import tcmp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     match_evt,
   input  pin_act_e act_q,
   input  logic     force_req,
   input  pin_act_e force_act,
   output logic     pin_q
);

   pin_act_e sel_act;

   always_comb begin
      sel_act = force_req ? force_act : act_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (force_req || match_evt) begin
         pin_q <= pin_next(sel_act, pin_q);
      end
   end

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
   import tcmp_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int CNT_W   = 16,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_tick,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [BUS_W-1:0] wr_data,
   input  logic [2:0]       rd_addr,
   output logic [BUS_W-1:0] rd_data,
   output logic             wave_out
);

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("tcmp_channel: CNT_W must be twice BUS_W");
      end
      if (BUS_W < 4) begin : g_bad_bus
         $error("tcmp_channel: BUS_W must hold the control field");
      end
   endgenerate

   logic             cnt_ld, cmp_ld, force_req, flag_clr;
   logic [CNT_W-1:0] ld_val, cnt_val, cmp_act;
   pin_act_e         mode_q, force_act;
   logic             pwm_q, match_evt, flag_q, blk_q;

   tcmp_regif #(.BUS_W(BUS_W), .CNT_W(CNT_W), .HAS_PWM(HAS_PWM)) u_regif (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_ld(cnt_ld), .cmp_ld(cmp_ld), .ld_val(ld_val), .act_q(mode_q),
      .pwm_q(pwm_q), .force_req(force_req), .force_act(force_act), .flag_clr(flag_clr)
   );

   tcmp_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .cnt_ld(cnt_ld), .ld_val(ld_val),
      .restart(match_evt && pwm_q), .cnt_q(cnt_val)
   );

   tcmp_match #(.CNT_W(CNT_W), .HAS_PWM(HAS_PWM)) u_match (
      .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .cnt_q(cnt_val), .cnt_ld(cnt_ld),
      .cmp_ld(cmp_ld), .ld_val(ld_val), .pwm_q(pwm_q), .flag_clr(flag_clr),
      .cmp_act_q(cmp_act), .match_evt(match_evt), .flag_q(flag_q), .blk_q(blk_q)
   );

   tcmp_wave u_wave (
      .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .act_q(mode_q),
      .force_req(force_req), .force_act(force_act), .pin_q(wave_out)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CNT_LO: rd_data = cnt_val[BUS_W-1:0];
         A_CNT_HI: rd_data = cnt_val[CNT_W-1:BUS_W];
         A_CMP_LO: rd_data = cmp_act[BUS_W-1:0];
         A_CMP_HI: rd_data = cmp_act[CNT_W-1:BUS_W];
         A_CTRL: begin
            rd_data[CTRL_ACT_LSB +: 2] = mode_q;
            rd_data[CTRL_MODE_BIT]     = pwm_q;
         end
         A_STAT:   rd_data[0] = flag_q;
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/tcmp_channel_chk.sv
module tcmp_channel_chk #(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmr_tick,
   input logic             wr_en,
   input logic [2:0]       wr_addr,
   input logic [BUS_W-1:0] wr_data,
   input logic             wave_out,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] cmp_act,
   input logic [1:0]       mode_q,
   input logic             pwm_q,
   input logic             flag_q,
   input logic             blk_q
);

   logic cnt_wr, ctrl_wr;
   assign cnt_wr  = wr_en && (wr_addr == 3'd0);
   assign ctrl_wr = wr_en && (wr_addr == 3'd4);

   // R4: no tick, no load -> counter holds
   p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_tick && !cnt_wr) |=> $stable(cnt_val));

   // R4: free-running step
   p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_tick && !cnt_wr && !pwm_q) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

   // R2: high-byte write leaves compare untouched
   p_cmp_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == 3'd3) && !tmr_tick) |=> $stable(cmp_act));

   // R9: a suppressed tick never raises the flag
   p_blk_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_q && tmr_tick) |=> !$rose(flag_q));

   // R6: action 00 and no control write -> pin steady
   p_none_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 2'd0) && !ctrl_wr) |=> $stable(wave_out));

   // R7: force touches neither flag nor counter
   p_force_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[3] && !tmr_tick) |=> (!$rose(flag_q) && $stable(cnt_val)));

   // R11: period end restarts the counter
   p_period_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_q && tmr_tick && !cnt_wr && !blk_q && (cnt_val == cmp_act)) |=> (cnt_val == '0));

endmodule

bind tcmp_channel tcmp_channel_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .wave_out(wave_out), .cnt_val(cnt_val), .cmp_act(cmp_act),
   .mode_q(mode_q), .pwm_q(pwm_q), .flag_q(flag_q), .blk_q(blk_q)
);

// File: tb/tcmp_channel_bench.sv
`timescale 1ns/1ps
module tcmp_channel_bench;

   localparam real HALF = 2.5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       wave_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   tcmp_channel u_tcmp_channel (
      .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wave_out(wave_out)
   );

   always #(HALF) clk = ~clk;

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd8(input logic [2:0] a, output logic [7:0] v);
      rd_addr = a; #0.5; v = rd_data;
   endtask

   task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
      logic [7:0] l, h;
      rd8(lo, l); rd8(lo + 3'd1, h); v = {h, l};
   endtask

   task automatic set_cnt(input logic [15:0] v);
      bus_wr(3'd1, v[15:8]); bus_wr(3'd0, v[7:0]);
   endtask

   task automatic set_cmp(input logic [15:0] v);
      bus_wr(3'd3, v[15:8]); bus_wr(3'd2, v[7:0]);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tmr_tick = 1'b1;
      repeat (n) @(negedge clk);
      tmr_tick = 1'b0;
   endtask

   task automatic flag_now(output logic f);
      logic [7:0] s;
      rd8(3'd5, s); f = s[0];
   endtask

   task automatic t_reset;
      logic [15:0] v; logic [7:0] b;
      rd16(3'd0, v); check("R1 counter", v, 0);
      rd16(3'd2, v); check("R1 compare", v, 0);
      rd8(3'd4, b);  check("R1 control", b, 0);
      rd8(3'd5, b);  check("R1 flag", b, 0);
      check("R1 pin", wave_out, 0);
   endtask

   task automatic t_byte_load;
      logic [15:0] v;
      bus_wr(3'd3, 8'h12);
      rd16(3'd2, v); check("R2 compare after high byte", v, 16'h0000);
      bus_wr(3'd2, 8'h34);
      rd16(3'd2, v); check("R3 compare after low byte", v, 16'h1234);
      bus_wr(3'd1, 8'h00);
      rd16(3'd0, v); check("R2 counter after high byte", v, 16'h0000);
   endtask

   task automatic t_count;
      logic [15:0] v;
      set_cnt(16'h0005);
      ticks(3);
      rd16(3'd0, v); check("R4 advance", v, 16'h0008);
      repeat (3) @(negedge clk);
      rd16(3'd0, v); check("R4 hold", v, 16'h0008);
      set_cnt(16'hFFFE);
      ticks(3);
      rd16(3'd0, v); check("R4 wrap", v, 16'h0001);
   endtask

   task automatic t_match_modes;
      logic f;
      set_cmp(16'h0010);
      bus_wr(3'd4, 8'h01);
      bus_wr(3'd5, 8'h01);
      set_cnt(16'h000E);
      ticks(3);
      flag_now(f); check("R5 flag set", f, 1);
      check("R6 toggle", wave_out, 1);
      bus_wr(3'd5, 8'h00);
      flag_now(f); check("R5 write 0 keeps flag", f, 1);
      bus_wr(3'd5, 8'h01);
      flag_now(f); check("R5 write 1 clears flag", f, 0);
      bus_wr(3'd4, 8'h02);
      set_cnt(16'h000F); ticks(2);
      check("R6 clear", wave_out, 0);
      bus_wr(3'd4, 8'h03);
      set_cnt(16'h000F); ticks(2);
      check("R6 set", wave_out, 1);
      bus_wr(3'd4, 8'h00);
      bus_wr(3'd5, 8'h01);
      set_cnt(16'h000F); ticks(2);
      check("R6 none keeps pin", wave_out, 1);
      flag_now(f); check("R5 flag with action none", f, 1);
   endtask

   task automatic t_force;
      logic f; logic [15:0] v; logic [7:0] b;
      bus_wr(3'd5, 8'h01);
      set_cnt(16'h0100);
      bus_wr(3'd4, 8'h09);
      check("R7 force toggles pin", wave_out, 0);
      flag_now(f); check("R7 force leaves flag", f, 0);
      rd16(3'd0, v); check("R7 force leaves counter", v, 16'h0100);
      rd8(3'd4, b);  check("R7 force bit reads 0", b, 8'h01);
   endtask

   task automatic t_block;
      logic f; logic [15:0] v;
      set_cnt(16'h0010);
      repeat (5) @(negedge clk);
      ticks(1);
      flag_now(f); check("R9 late tick still blocked", f, 0);
      rd16(3'd0, v); check("R9 counter advances", v, 16'h0011);
      check("R9 pin untouched", wave_out, 0);
   endtask

   task automatic t_period;
      logic f; logic [15:0] v; logic [7:0] b;
      bus_wr(3'd4, 8'h05);
      check("R13 pin kept entering period mode", wave_out, 0);
      set_cmp(16'h0020);
      rd16(3'd2, v); check("R11 compare shadowed", v, 16'h0010);
      set_cnt(16'h000D);
      ticks(4);
      rd16(3'd0, v); check("R11 counter restarts", v, 16'h0000);
      rd16(3'd2, v); check("R11 shadow promoted", v, 16'h0020);
      check("R11 pin toggled at period end", wave_out, 1);
      flag_now(f); check("R11 flag at period end", f, 1);
      bus_wr(3'd5, 8'h01);
      bus_wr(3'd4, 8'h0D);
      check("R8 force ignored", wave_out, 1);
      rd8(3'd4, b); check("R8 control readback", b, 8'h05);
   endtask

   task automatic t_mode_change;
      bus_wr(3'd4, 8'h0A);
      check("R7 force clear", wave_out, 0);
      bus_wr(3'd4, 8'h07);
      check("R13 pin kept on mode switch", wave_out, 0);
      set_cnt(16'h001E);
      ticks(3);
      check("R10 new action used at once", wave_out, 1);
   endtask

   task automatic t_lost_top;
      logic f; logic [15:0] v;
      bus_wr(3'd5, 8'h01);
      set_cnt(16'h0020);
      ticks(1);
      rd16(3'd0, v); check("R12 top match lost", v, 16'h0021);
      ticks(16'hFFDF);
      rd16(3'd0, v); check("R12 wrapped through 0xFFFF", v, 16'h0000);
      flag_now(f); check("R12 no flag on run-out", f, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_load();
      t_count();
      t_match_modes();
      t_force();
      t_block();
      t_period();
      t_mode_change();
      t_lost_top();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(2.0 * HALF * 190000.0);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule